// File: doc/BRIEF.md
# Multi-Sector Erase Controller

This block is the erase front end of a byte-wide flash-style memory. It watches the chip-enable, write-enable and output-enable strobes, the address and the data byte of a parallel bus, and decodes a six-write erase command. The first five writes are fixed unlock and setup writes. The sixth write carries the byte 30h and selects the sector that holds its address. Further 30h writes add more sectors while a timed acceptance window is open, and each one restarts that window. When the window expires without a new selection, the block erases every selected sector one after another, from the lowest index upwards. Each sector takes a fixed number of clock cycles. When all of them are done, the block returns to read mode.

While a command is pending or running, every bus read returns a status byte instead of array data. Bit 7 reads 0 until the work is done. Bit 6 flips after each completed read. Bit 3 reports whether the acceptance window is still open (0) or the erase has started (1). An active-low busy output stays asserted for the same period. The memory itself is a plain register array of 16 sectors. Erased bytes read FFh. Software polls an address inside an erased sector until bit 7 reads 1.

All bus strobes are sampled by the block clock. A write takes effect on the first clock edge after the combined write strobe (chip enable and write enable both low) goes inactive. Address and data are captured while that strobe is active.

Top module: `multi_sector_erase`

## Requirements
- R1: A command begins only with the exact unlock order: AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh. Any write whose address or data does not match the expected step returns the block to read mode, and busyN stays high.
- R2: A sixth write of 30h selects the sector given by address bits [15:12] and opens the acceptance window. busyN goes low, and reads return a status byte with bit 3 = 0 and bit 7 = 0.
- R3: Each further 30h write during the window adds its sector and restarts the window. The erase starts exactly WINDOW_CYCLES clock cycles after the last accepted 30h write; from then on status bit 3 reads 1.
- R4: Any write with data other than 30h during the window cancels all pending selections and returns to read mode. busyN goes high and no sector is erased.
- R5: During the erase, status bit 7 reads 0, bit 3 reads 1, bits 5, 4, 2, 1 and 0 read 0, and busyN is low. Every bus write, including a complete new erase command, is ignored and does not change the completion time.
- R6: While busyN is low, status bit 6 holds steady during a read and flips after each completed read (chip enable and output enable both low, then released).
- R7: Each selected sector takes ERASE_CYCLES cycles, and the sectors are worked one at a time. busyN returns high exactly WINDOW_CYCLES + N*ERASE_CYCLES cycles after the last 30h write, where N is the number of selected sectors. Every byte of a selected sector then reads FFh, and unselected sectors are left unchanged.
- R8: In read mode, a read returns the array byte at address bits [15:12] (sector) and [OFFSET_W-1:0] (byte). Polling an erased sector therefore gives FFh, with bit 7 = 1.
- R9: Reset during an erase stops it at once. busyN goes high, the block is in read mode, and a new erase command on the same sector is then accepted and completes.
- R10: Out of reset, busyN is high, and dataOutEn is high exactly when chip enable and output enable are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all bus strobes are sampled on its rising edge |
| rstN | input | 1 | Active-low hardware reset |
| ceN | input | 1 | Active-low chip enable |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address; bits [15:12] pick the sector |
| dataIn | input | 8 | Write data byte |
| dataOut | output | 8 | Array byte in read mode, status byte while busy |
| dataOutEn | output | 1 | High while a read is in progress (drive enable for the data pins) |
| busyN | output | 1 | Low from the first sector selection until the erase completes |

## Verification
A write is decoded on the clock edge after its write strobe is released, so the bench counts every delay from the falling clock edge that follows that decode edge. Status bit 3 is checked one cycle before and exactly at the WINDOW_CYCLES mark. busyN is checked one cycle before and exactly at WINDOW_CYCLES + N*ERASE_CYCLES, including a run in which a full command is written in the middle of an erase to show that the completion time does not move. Status and array reads are combinational on the address and sampled on the falling edge. The toggle bit is compared between two back-to-back reads, because it only flips on the edge after a read ends.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;

  // Sector index width; the array always has 2**SEC_W sectors.
  localparam int SEC_W = 4;

  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_AA        = 8'hAA;
  localparam logic [7:0]  KEY_55        = 8'h55;
  localparam logic [7:0]  KEY_SETUP     = 8'h80;
  localparam logic [7:0]  KEY_SECTOR    = 8'h30;
  localparam logic [7:0]  ERASED_BYTE   = 8'hFF;

  typedef enum logic [3:0] {
    ST_READ,
    ST_C1,
    ST_C2,
    ST_C3,
    ST_C4,
    ST_C5,
    ST_WIN,
    ST_ERASE
  } ctlState_t;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic             selStrobe;    // a 30h selection is accepted this cycle
    logic             windowOpen;   // acceptance window running
    logic             eraseActive;  // internal erase running
    logic             eraseGo;      // current sector finishes this cycle
    logic [SEC_W-1:0] eraseSector;  // sector being erased
    logic             readDone;     // a bus read ended this cycle
  } ctlStrobe_t;

endpackage

// File: rtl/sec_erase_ctrl.sv
module sec_erase_ctrl
  import sec_erase_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int WINDOW_CYCLES = 4000,
  parameter int ERASE_CYCLES  = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output ctlStrobe_t        stb
);

  localparam int SECTORS = 1 << SEC_W;
  localparam int WIN_W   = $clog2(WINDOW_CYCLES + 1);
  localparam int ERS_W   = $clog2(ERASE_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WINDOW_CYCLES - 1);
  localparam logic [ERS_W-1:0] ERS_LOAD = ERS_W'(ERASE_CYCLES - 1);

  ctlState_t          state;
  logic [SECTORS-1:0] selMask;
  logic [WIN_W-1:0]   winCnt;
  logic [ERS_W-1:0]   eraseCnt;
  logic [SEC_W-1:0]   curSec;
  logic               writeLowQ, readLowQ;
  logic [ADDR_W-1:0]  addrQ;
  logic [7:0]         dataQ;

  logic               writeLow, readLow, wrFire, rdDone;
  logic               stepOk, isSel;
  logic [SEC_W-1:0]   wrSector;
  logic [SECTORS-1:0] wrBit, nextMask;
  logic               eraseGo;
  ctlState_t          unlockNext;

  function automatic logic [SEC_W-1:0] lowestSet(input logic [SECTORS-1:0] m);
    logic [SEC_W-1:0] idx;
    idx = '0;
    for (int i = SECTORS - 1; i >= 0; i--) begin
      if (m[i]) idx = SEC_W'(i);
    end
    return idx;
  endfunction

  // Bus strobe sampling
  assign writeLow = !weN && !ceN;
  assign readLow  = !oeN && !ceN;
  assign wrFire   = writeLowQ && !writeLow;
  assign rdDone   = readLowQ && !readLow;

  assign wrSector = addrQ[ADDR_W-1 -: SEC_W];
  assign wrBit    = SECTORS'(1) << wrSector;
  assign isSel    = (dataQ == KEY_SECTOR);
  assign nextMask = selMask & ~(SECTORS'(1) << curSec);
  assign eraseGo  = (state == ST_ERASE) && (eraseCnt == '0);

  // Expected unlock step for the current state
  always_comb begin
    stepOk     = 1'b0;
    unlockNext = ST_READ;
    unique case (state)
      ST_READ: begin
        stepOk     = (addrQ == ADDR_W'(UNLOCK_ADDR_A)) && (dataQ == KEY_AA);
        unlockNext = ST_C1;
      end
      ST_C1: begin
        stepOk     = (addrQ == ADDR_W'(UNLOCK_ADDR_B)) && (dataQ == KEY_55);
        unlockNext = ST_C2;
      end
      ST_C2: begin
        stepOk     = (addrQ == ADDR_W'(UNLOCK_ADDR_A)) && (dataQ == KEY_SETUP);
        unlockNext = ST_C3;
      end
      ST_C3: begin
        stepOk     = (addrQ == ADDR_W'(UNLOCK_ADDR_A)) && (dataQ == KEY_AA);
        unlockNext = ST_C4;
      end
      ST_C4: begin
        stepOk     = (addrQ == ADDR_W'(UNLOCK_ADDR_B)) && (dataQ == KEY_55);
        unlockNext = ST_C5;
      end
      default: begin
        stepOk     = 1'b0;
        unlockNext = ST_READ;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeLowQ <= 1'b0;
      readLowQ  <= 1'b0;
      addrQ     <= '0;
      dataQ     <= '0;
    end else begin
      writeLowQ <= writeLow;
      readLowQ  <= readLow;
      if (writeLow) begin
        addrQ <= addr;
        dataQ <= dataIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_READ;
      selMask  <= '0;
      winCnt   <= '0;
      eraseCnt <= '0;
      curSec   <= '0;
    end else begin
      unique case (state)
        ST_ERASE: begin
          // bus writes are not looked at here
          if (eraseGo) begin
            selMask <= nextMask;
            if (nextMask == '0) begin
              state <= ST_READ;
            end else begin
              curSec   <= lowestSet(nextMask);
              eraseCnt <= ERS_LOAD;
            end
          end else begin
            eraseCnt <= eraseCnt - 1'b1;
          end
        end
        ST_WIN: begin
          if (wrFire) begin
            if (isSel) begin
              selMask <= selMask | wrBit;
              winCnt  <= WIN_LOAD;
            end else begin
              selMask <= '0;
              state   <= ST_READ;
            end
          end else if (winCnt == '0) begin
            state    <= ST_ERASE;
            curSec   <= lowestSet(selMask);
            eraseCnt <= ERS_LOAD;
          end else begin
            winCnt <= winCnt - 1'b1;
          end
        end
        ST_C5: begin
          if (wrFire) begin
            if (isSel) begin
              selMask <= wrBit;
              winCnt  <= WIN_LOAD;
              state   <= ST_WIN;
            end else begin
              state <= ST_READ;
            end
          end
        end
        default: begin
          if (wrFire) state <= stepOk ? unlockNext : ST_READ;
        end
      endcase
    end
  end

  assign stb.selStrobe   = wrFire && isSel && ((state == ST_C5) || (state == ST_WIN));
  assign stb.windowOpen  = (state == ST_WIN);
  assign stb.eraseActive = (state == ST_ERASE);
  assign stb.eraseGo     = eraseGo;
  assign stb.eraseSector = curSec;
  assign stb.readDone    = rdDone;

endmodule

// File: rtl/sec_erase_data.sv
module sec_erase_data
  import sec_erase_pkg::*;
#(
  parameter int OFFSET_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceN,
  input  logic                oeN,
  input  logic [SEC_W-1:0]    rdSector,
  input  logic [OFFSET_W-1:0] rdOffset,
  input  ctlStrobe_t          stb,
  output logic [7:0]          dataOut,
  output logic                dataOutEn,
  output logic                busyN
);

  localparam int SECTORS = 1 << SEC_W;
  localparam int BYTES   = 1 << OFFSET_W;

  logic       statusMode;
  logic       toggleBit;
  logic [7:0] statusByte;
  logic [7:0] secByte [SECTORS];

  assign statusMode = stb.windowOpen || stb.eraseActive;

  // Behavioural array: one bank of bytes per sector, no reset
  for (genvar s = 0; s < SECTORS; s++) begin : g_sec
    logic [7:0] cells [BYTES];
    always_ff @(posedge clk) begin
      if (stb.eraseGo && (stb.eraseSector == SEC_W'(s))) begin
        for (int o = 0; o < BYTES; o++) cells[o] <= ERASED_BYTE;
      end
    end
    assign secByte[s] = cells[rdOffset];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleBit <= 1'b0;
    end else if (stb.selStrobe && !stb.windowOpen) begin
      toggleBit <= 1'b0;
    end else if (statusMode && stb.readDone) begin
      toggleBit <= ~toggleBit;
    end
  end

  assign statusByte = {1'b0, toggleBit, 2'b00, stb.eraseActive, 3'b000};
  assign dataOut    = statusMode ? statusByte : secByte[rdSector];
  assign dataOutEn  = !ceN && !oeN;
  assign busyN      = !statusMode;

endmodule

// File: rtl/multi_sector_erase.sv
module multi_sector_erase
  import sec_erase_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int OFFSET_W      = 4,
  parameter int WINDOW_CYCLES = 4000,
  parameter int ERASE_CYCLES  = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOutEn,
  output logic              busyN
);

  ctlStrobe_t stb;

  sec_erase_ctrl #(
    .ADDR_W       (ADDR_W),
    .WINDOW_CYCLES(WINDOW_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ceN   (ceN),
    .weN   (weN),
    .oeN   (oeN),
    .addr  (addr),
    .dataIn(dataIn),
    .stb   (stb)
  );

  sec_erase_data #(
    .OFFSET_W(OFFSET_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .oeN      (oeN),
    .rdSector (addr[ADDR_W-1 -: SEC_W]),
    .rdOffset (addr[OFFSET_W-1:0]),
    .stb      (stb),
    .dataOut  (dataOut),
    .dataOutEn(dataOutEn),
    .busyN    (busyN)
  );

endmodule

// File: rtl/multi_sector_erase_chk.sv
module multi_sector_erase_chk
  import sec_erase_pkg::*;
#(
  parameter int WINDOW_CYCLES = 4000,
  parameter int ERASE_CYCLES  = 1000
) (
  input logic       clk,
  input logic       rstN,
  input logic       busyN,
  input logic [7:0] dataOut,
  input logic       dataOutEn,
  input ctlStrobe_t stb
);

  logic [31:0] winAge;
  logic [31:0] ersAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winAge <= '0;
      ersAge <= '0;
    end else begin
      winAge <= stb.selStrobe ? '0 : (stb.windowOpen ? winAge + 1 : '0);
      ersAge <= (!stb.eraseActive || stb.eraseGo) ? '0 : ersAge + 1;
    end
  end

  assert_window_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.eraseActive) |-> (winAge == 32'(WINDOW_CYCLES)));

  assert_d7_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && dataOutEn) |-> !dataOut[7]);

  assert_status_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && dataOutEn) |->
      (dataOut[5:4] == 2'b00 && dataOut[2:0] == 3'b000 && dataOut[3] == stb.eraseActive));

  assert_erase_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eraseActive && !stb.eraseGo) |=> stb.eraseActive);

  assert_d6_steady_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && dataOutEn && $past(!busyN && dataOutEn)) |-> (dataOut[6] == $past(dataOut[6])));

  assert_read_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.readDone |-> !dataOutEn);

  assert_sector_time_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseGo |-> (stb.eraseActive && ersAge == 32'(ERASE_CYCLES - 1)));

  assert_sector_steady_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eraseActive && $past(stb.eraseActive) && !$past(stb.eraseGo)) |-> $stable(stb.eraseSector));

  assert_busy_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyN) |-> ($past(stb.eraseGo) || $past(stb.windowOpen)));

endmodule

bind multi_sector_erase multi_sector_erase_chk #(
  .WINDOW_CYCLES(WINDOW_CYCLES),
  .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busyN    (busyN),
  .dataOut  (dataOut),
  .dataOutEn(dataOutEn),
  .stb      (stb)
);

// File: tb/test_multi_sector_erase.sv
module test_multi_sector_erase;

  localparam int W = 40;
  localparam int E = 30;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ceN, weN, oeN;
  logic [15:0] addr;
  logic [7:0]  dataIn;
  logic [7:0]  dataOut;
  logic        dataOutEn;
  logic        busyN;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  multi_sector_erase #(
    .ADDR_W(16), .OFFSET_W(4), .WINDOW_CYCLES(W), .ERASE_CYCLES(E)
  ) i_multi_sector_erase (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn), .busyN(busyN)
  );

  // {expected busyN after the write, address, data}
  localparam logic [24:0] VEC [13] = '{
    {1'b1, 16'h5555, 8'hAA},
    {1'b1, 16'h2AAA, 8'h55},
    {1'b1, 16'h5555, 8'h90},  // wrong setup byte
    {1'b1, 16'h5555, 8'hAA},
    {1'b1, 16'h2AAB, 8'h55},  // wrong address
    {1'b1, 16'h5555, 8'hAA},
    {1'b1, 16'h2AAA, 8'h55},
    {1'b1, 16'h5555, 8'h80},
    {1'b1, 16'h5555, 8'hAA},
    {1'b1, 16'h2AAA, 8'h55},
    {1'b0, 16'h3010, 8'h30},
    {1'b0, 16'h7010, 8'h30},
    {1'b1, 16'h0000, 8'hF0}   // cancels the window
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    tick();
    weN = 1'b1; ceN = 1'b1;
    tick();
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    tick();
    d = dataOut;
    oeN = 1'b1; ceN = 1'b1;
    tick();
  endtask

  task automatic eraseCmd(input logic [3:0] sec);
    busWrite(16'h5555, 8'hAA);
    busWrite(16'h2AAA, 8'h55);
    busWrite(16'h5555, 8'h80);
    busWrite(16'h5555, 8'hAA);
    busWrite(16'h2AAA, 8'h55);
    busWrite({sec, 12'h010}, 8'h30);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] d1, d2;
    rstN = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1; addr = '0; dataIn = '0;
    repeat (3) tick();
    chk("R10 busyN in reset", 16'(busyN), 16'd1);
    chk("R10 dataOutEn idle", 16'(dataOutEn), 16'd0);
    rstN = 1'b1;
    tick();
    addr = 16'h0000; ceN = 1'b0; oeN = 1'b0;
    tick();
    chk("R10 dataOutEn on read", 16'(dataOutEn), 16'd1);
    chk("R10 busyN idle", 16'(busyN), 16'd1);
    ceN = 1'b1; oeN = 1'b1;
    tick();

    // Vector walk: unlock decode, selection and cancel
    for (int i = 0; i < 13; i++) begin
      busWrite(VEC[i][23:8], VEC[i][7:0]);
      if (i < 10)      chk("R1 unlock step busyN", 16'(busyN), 16'(VEC[i][24]));
      else if (i < 12) chk("R2 selection busyN", 16'(busyN), 16'(VEC[i][24]));
      else             chk("R4 cancel busyN", 16'(busyN), 16'(VEC[i][24]));
    end
    repeat (W + 2 * E + 5) tick();
    busRead(16'h3010, d1);
    chk("R4 sector 3 kept", 16'(d1 !== 8'hFF), 16'd1);
    busRead(16'h7010, d1);
    chk("R4 sector 7 kept", 16'(d1 !== 8'hFF), 16'd1);

    // Retriggered window: sectors 9, 2, 14
    eraseCmd(4'd9);
    repeat (30) tick();
    busWrite(16'h2010, 8'h30);
    repeat (30) tick();
    busWrite(16'hE010, 8'h30);
    addr = 16'hE010; ceN = 1'b0; oeN = 1'b0;
    repeat (W - 1) tick();
    chk("R3 D3 open before expiry", 16'(dataOut[3]), 16'd0);
    chk("R2 busyN low in window", 16'(busyN), 16'd0);
    tick();
    chk("R3 D3 set at expiry", 16'(dataOut[3]), 16'd1);
    repeat (3 * E - 1) tick();
    chk("R7 busyN low before end", 16'(busyN), 16'd0);
    tick();
    chk("R7 busyN high at end", 16'(busyN), 16'd1);
    chk("R8 poll reads FF", 16'(dataOut), 16'h00FF);
    ceN = 1'b1; oeN = 1'b1;
    tick();
    busRead(16'h9010, d1);
    chk("R7 sector 9 erased", 16'(d1), 16'h00FF);
    busRead(16'h2005, d1);
    chk("R7 sector 2 erased", 16'(d1), 16'h00FF);
    busRead(16'h5010, d1);
    chk("R7 sector 5 untouched", 16'(d1 !== 8'hFF), 16'd1);

    // Writes ignored during erase
    eraseCmd(4'd1);
    repeat (W + 2) tick();
    eraseCmd(4'd12);
    repeat (E - 15) tick();
    chk("R5 busyN low before end", 16'(busyN), 16'd0);
    tick();
    chk("R5 completion time unchanged", 16'(busyN), 16'd1);
    busRead(16'hC010, d1);
    chk("R5 ignored sector kept", 16'(d1 !== 8'hFF), 16'd1);
    busRead(16'h1010, d1);
    chk("R7 sector 1 erased", 16'(d1), 16'h00FF);

    // Toggle bit, erase status, reset abort
    eraseCmd(4'd6);
    busRead(16'h6010, d1);
    chk("R2 window D3", 16'(d1[3]), 16'd0);
    chk("R2 window D7", 16'(d1[7]), 16'd0);
    busRead(16'h6010, d2);
    chk("R6 toggle in window", 16'(d2[6] != d1[6]), 16'd1);
    repeat (W) tick();
    busRead(16'h6010, d1);
    chk("R5 erase D3", 16'(d1[3]), 16'd1);
    chk("R5 erase D7", 16'(d1[7]), 16'd0);
    busRead(16'h6010, d2);
    chk("R6 toggle in erase", 16'(d2[6] != d1[6]), 16'd1);
    rstN = 1'b0;
    tick();
    chk("R9 busyN after reset", 16'(busyN), 16'd1);
    tick();
    rstN = 1'b1;
    tick();
    chk("R9 read mode after reset", 16'(busyN), 16'd1);
    eraseCmd(4'd6);
    chk("R9 command accepted", 16'(busyN), 16'd0);
    for (int n = 0; n < W + E + 10; n++) begin
      if (busyN) break;
      tick();
    end
    busRead(16'h6010, d1);
    chk("R9 restarted erase completes", 16'(d1), 16'h00FF);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule